// File: doc/BRIEF.md
# Asynchronous Rising-Edge Capture and Phase-Tagged Synchronizer

This block watches a free-running input that has no clock of its own and turns every rising transition on it into a single-cycle event in the system clock domain. The input clocks a capture flop whose data input is held at one. This latches pulses far shorter than a clock period. The captured level then crosses into the clock domain on two independent chains. One chain samples on the rising clock edge and the other on the falling clock edge, and every flop in a chain uses the same edge.

A merge stage in the rising-edge domain emits the event strobe together with a tag bit. The tag records which of the two chains saw the capture first, so the time of the event is known to within half a clock period. Once the event has been taken, a re-arm controller clears the capture flop. It keeps the flop cleared until both chains read low again, so that a stale level can never hide or merge the next transition.

The latency, the re-arm dead time and the minimum event spacing all scale with the chain depth parameter `SYNC_STAGES`, which defaults to 2.

Top module: `edge_capture_sync`

## Requirements
- R1: A rising edge on `async_in` is captured and reported when the capture flop is armed, even when the high pulse lasts only 2 ns.
- R2: The strobe becomes visible right after the (SYNC_STAGES+1)-th rising clock edge that follows the input edge. With the default depth this is the third edge.
- R3: Each accepted input edge produces exactly one strobe, and that strobe is high for exactly one clock cycle.
- R4: The tag `evt_fall_first` is 1 when the input edge falls in the first half of the clock period after a rising clock edge, because the falling-edge chain sees it first. It is 0 when the edge falls in the second half, because the rising-edge chain sees it first. The tag is loaded in the same cycle as the strobe.
- R5: Between strobes the tag keeps its last value.
- R6: The capture clear is raised in the cycle after the last rising-chain stage reads high. It is dropped only after every stage of both chains has read low.
- R7: While `rst` is high, the capture flop is held cleared. In the cycle after `rst` is sampled high, the strobe, the tag and both chains are 0.
- R8: A rising edge that arrives while the capture flop is already set, or while the clear is held, produces no strobe.
- R9: Holding `async_in` high for many cycles yields only the single strobe of its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also holds the capture flop cleared |
| async_in | input | 1 | Asynchronous input whose rising transitions are detected |
| evt_strobe | output | 1 | One-cycle event strobe, registered |
| evt_fall_first | output | 1 | Phase tag: 1 = falling-edge chain first, 0 = rising-edge chain first |

## Verification
The assertions assume that consecutive rising edges on `async_in` are at least 2*SYNC_STAGES+3 clock cycles apart. This spacing lets the clear from the previous event drain through both chains before the next edge can arrive. They also assume that input edges never coincide exactly with a clock edge, so the tag is well defined. The stimulus starts every pulse at an offset from a rising clock edge, in 0.1 ns steps that never land on 0, on half a period or on a full period. It waits at least eight cycles before the next event. Edges inside the dead time, and edges during reset, are placed on purpose and are expected to produce no strobe.

// File: rtl/edge_cap_pkg.sv
`timescale 1ns/1ps
package edge_cap_pkg;

  // Which synchronizer chain observed the captured level first.
  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } phase_e;

  // Cycles from the input edge until the clear is released (worst case).
  function automatic int unsigned rearm_cycles(input int unsigned stages);
    return 2 * stages + 2;
  endfunction

endpackage

// File: rtl/edge_cap_latch.sv
`timescale 1ns/1ps
// Pulse catcher: the asynchronous input is used as a clock, data tied high.
module edge_cap_latch (
  input  logic async_in,
  input  logic clr,
  output logic cap_q
);

  always_ff @(posedge async_in or posedge clr) begin
    if (clr) cap_q <= 1'b0;
    else     cap_q <= 1'b1;
  end

endmodule

// File: rtl/edge_cap_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer; every stage of one instance uses the same edge.
module edge_cap_sync #(
  parameter int STAGES  = 2,
  parameter bit ON_FALL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] stages
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[TOP-1:0], din};
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[TOP-1:0], din};
      end
    end
  endgenerate

  assign stages = chain_q;

endmodule

// File: rtl/edge_cap_rearm.sv
`timescale 1ns/1ps
// Clear handshake: raise once the event is seen, drop once both chains drained.
module edge_cap_rearm #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] rise_vec,
  input  logic [STAGES-1:0] fall_vec,
  output logic              clr_q
);

  localparam int LAST = STAGES - 1;

  logic seen_high;
  logic drained;

  assign seen_high = rise_vec[LAST];
  assign drained   = (rise_vec == '0) && (fall_vec == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q <= 1'b0;
    end else if (!clr_q && seen_high) begin
      clr_q <= 1'b1;
    end else if (clr_q && drained) begin
      clr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/edge_cap_merge.sv
`timescale 1ns/1ps
// Edge detect on the rising chain and phase tag taken from the falling chain.
module edge_cap_merge
  import edge_cap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_last,
  input  logic fall_last,
  output logic evt_strobe,
  output logic evt_fall_first
);

  logic   rise_d_q;
  logic   fall_smp_q;
  logic   strobe_q;
  phase_e tag_q;
  logic   new_evt;

  assign new_evt = rise_last && !rise_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_d_q   <= 1'b0;
      fall_smp_q <= 1'b0;
      strobe_q   <= 1'b0;
      tag_q      <= PH_RISE;
    end else begin
      rise_d_q   <= rise_last;
      fall_smp_q <= fall_last;
      strobe_q   <= new_evt;
      if (new_evt) tag_q <= fall_smp_q ? PH_FALL : PH_RISE;
    end
  end

  assign evt_strobe     = strobe_q;
  assign evt_fall_first = (tag_q == PH_FALL);

endmodule

// File: rtl/edge_capture_sync.sv
`timescale 1ns/1ps
module edge_capture_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic evt_strobe,
  output logic evt_fall_first
);

  localparam int LAST = SYNC_STAGES - 1;

  logic                   cap_q;
  logic                   cap_clr;
  logic                   rearm_q;
  logic [SYNC_STAGES-1:0] rise_vec;
  logic [SYNC_STAGES-1:0] fall_vec;

  assign cap_clr = rst | rearm_q;

  edge_cap_latch u_latch (
    .async_in (async_in),
    .clr      (cap_clr),
    .cap_q    (cap_q)
  );

  edge_cap_sync #(.STAGES(SYNC_STAGES), .ON_FALL(1'b0)) u_rise_chain (
    .clk    (clk),
    .rst    (rst),
    .din    (cap_q),
    .stages (rise_vec)
  );

  edge_cap_sync #(.STAGES(SYNC_STAGES), .ON_FALL(1'b1)) u_fall_chain (
    .clk    (clk),
    .rst    (rst),
    .din    (cap_q),
    .stages (fall_vec)
  );

  edge_cap_rearm #(.STAGES(SYNC_STAGES)) u_rearm (
    .clk      (clk),
    .rst      (rst),
    .rise_vec (rise_vec),
    .fall_vec (fall_vec),
    .clr_q    (rearm_q)
  );

  edge_cap_merge u_merge (
    .clk            (clk),
    .rst            (rst),
    .rise_last      (rise_vec[LAST]),
    .fall_last      (fall_vec[LAST]),
    .evt_strobe     (evt_strobe),
    .evt_fall_first (evt_fall_first)
  );

endmodule

// File: rtl/edge_capture_sync_chk.sv
`timescale 1ns/1ps
module edge_capture_sync_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   evt_strobe,
  input logic                   evt_fall_first,
  input logic                   cap_q,
  input logic                   rearm_q,
  input logic [SYNC_STAGES-1:0] rise_vec,
  input logic [SYNC_STAGES-1:0] fall_vec
);

  localparam int LAST = SYNC_STAGES - 1;

  p_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    evt_strobe |=> !evt_strobe);

  p_strobe_after_sync_r2: assert property (@(posedge clk) disable iff (rst)
    evt_strobe |-> ($past(rise_vec[LAST]) && !$past(rise_vec[LAST], 2)));

  p_tag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !evt_strobe |-> $stable(evt_fall_first));

  p_clr_raise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rearm_q) |-> $past(rise_vec[LAST]));

  p_clr_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rearm_q) |-> ($past(rise_vec) == '0 && $past(fall_vec) == '0));

  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |=> (!evt_strobe && !evt_fall_first && rise_vec == '0));

  p_capture_held_r7: assert property (@(posedge clk)
    rst |=> !cap_q);

endmodule

bind edge_capture_sync edge_capture_sync_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .evt_strobe     (evt_strobe),
  .evt_fall_first (evt_fall_first),
  .cap_q          (cap_q),
  .rearm_q        (rearm_q),
  .rise_vec       (rise_vec),
  .fall_vec       (fall_vec)
);

// File: tb/edge_capture_sync_bench.sv
`timescale 1ns/1ps
module edge_capture_sync_bench;

  localparam int STAGES = 2;
  localparam int LAT    = STAGES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic async_in = 1'b0;
  logic evt_strobe;
  logic evt_fall_first;

  edge_capture_sync #(.SYNC_STAGES(STAGES)) u_edge_capture_sync (
    .clk            (clk),
    .rst            (rst),
    .async_in       (async_in),
    .evt_strobe     (evt_strobe),
    .evt_fall_first (evt_fall_first)
  );

  always #5 clk = ~clk;

  int pe_cnt = 0;
  always @(posedge clk) pe_cnt++;

  int n_cmp = 0;
  int n_bad = 0;
  int n_edges_exp = 0;
  int n_strobes = 0;
  bit pending = 1'b0;
  int exp_pe = 0;
  bit exp_tag = 1'b0;
  bit prev_strobe = 1'b0;
  bit last_tag = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected tag: first half after a rising clock edge -> falling chain first.
  function automatic bit tag_for(input int off_tenths);
    return (off_tenths < 50);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      pending     = 1'b0;
      prev_strobe = 1'b0;
      last_tag    = evt_fall_first;
    end else begin
      if (evt_strobe) begin
        n_strobes++;
        check(!prev_strobe, "R3", "strobe wider than one cycle", 1, 0);
        if (!pending) begin
          check(1'b0, "R8", "strobe without accepted edge", 1, 0);
        end else begin
          check(pe_cnt == exp_pe + LAT, "R2", "latency in rising edges",
                pe_cnt - exp_pe, LAT);
          check(evt_fall_first == exp_tag, "R4", "phase tag",
                int'(evt_fall_first), int'(exp_tag));
          pending = 1'b0;
        end
      end else begin
        check(evt_fall_first == last_tag, "R5", "tag changed without strobe",
              int'(evt_fall_first), int'(last_tag));
        if (pending && pe_cnt > exp_pe + LAT) begin
          check(1'b0, "R1", "missing strobe", 0, 1);
          pending = 1'b0;
        end
      end
      prev_strobe = evt_strobe;
      last_tag    = evt_fall_first;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Edge at off_tenths*0.1 ns after a rising clock edge, high for w_ps ps.
  task automatic fire(input int off_tenths, input int w_ps, input bit accepted);
    @(posedge clk);
    #(off_tenths * 0.1);
    async_in = 1'b1;
    if (accepted) begin
      pending = 1'b1;
      exp_pe  = pe_cnt;
      exp_tag = tag_for(off_tenths);
      n_edges_exp++;
    end
    #(w_ps * 0.001);
    async_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    check(1'b0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    idle(3);
    @(negedge clk);
    check(evt_strobe == 1'b0, "R7", "strobe in reset", int'(evt_strobe), 0);
    check(evt_fall_first == 1'b0, "R7", "tag in reset", int'(evt_fall_first), 0);
    rst = 1'b0;
    idle(2);

    // R1/R4: 2 ns pulses in each half of the period, near the midpoint too
    fire(20, 2000, 1'b1);  idle(9);
    fire(80, 2000, 1'b1);  idle(9);
    fire(49, 2000, 1'b1);  idle(9);
    fire(51, 2000, 1'b1);  idle(9);
    fire(1,  2000, 1'b1);  idle(9);
    fire(99, 2000, 1'b1);  idle(9);

    // R9: input held high for 15 cycles
    fire(30, 150000, 1'b1); idle(9);

    // R8: second edge while the capture flop is still set
    fire(30, 2000, 1'b1);
    fire(60, 2000, 1'b0);
    idle(9);

    // R8: second edge while the clear is held (4 cycles after the first)
    fire(70, 3000, 1'b1);
    idle(3);
    fire(20, 3000, 1'b0);
    idle(10);

    // R7: reset mid-run with an edge during reset; tag was 1 before
    fire(10, 2000, 1'b1); idle(9);
    @(negedge clk) rst = 1'b1;
    fire(40, 2000, 1'b0);
    idle(2);
    @(negedge clk);
    check(evt_fall_first == 1'b0, "R7", "tag after reset", int'(evt_fall_first), 0);
    rst = 1'b0;
    idle(8);

    // Random phases, widths and spacings
    for (int i = 0; i < 300; i++) begin
      int off;
      int w;
      off = $urandom_range(98, 1);
      if (off == 50) off = 51;
      w = $urandom_range(30000, 2000);
      fire(off, w, 1'b1);
      idle(7 + $urandom_range(3, 0));
    end

    idle(10);
    check(n_strobes == n_edges_exp, "R3", "strobe count vs edges",
          n_strobes, n_edges_exp);
    finish_run();
  end

endmodule